// File: doc/BRIEF.md
# USB Endpoint Buffer Handshake Controller

This block decides, for every data endpoint of a small USB function, whether the next host transaction gets ACK or NAK. It also tracks which side owns each packet buffer: the CPU or the serial packet engine. The function has a control endpoint with setup, IN and OUT directions, one single-buffered IN endpoint, and a pair of double-buffered endpoints, one IN and one OUT.

Software drives the block through an 8-bit command port. Each bit written as 1 is a one-shot request that hands a buffer over, and the port keeps no state. The packet engine reports completed traffic through single-cycle event pulses. The block answers on the ACK/NAK and buffer-index outputs one clock after the command or event.

The control endpoint is a two-state machine. CTL_HOLD refuses the data stage. CTL_DATA answers from the control buffer flags. The transitions are HOLD to DATA on the setup read-complete command, and any state to HOLD on a received setup packet.

The single IN endpoint has two states. SI_EMPTY goes to SI_LOADED on its load command. SI_LOADED goes back to SI_EMPTY when the host acknowledges the packet.

Each double-buffered endpoint counts how many of its buffers the engine holds: DB_NONE, DB_ONE or DB_BOTH. A command accepted from software moves the count up by one, and a packet completed by the engine moves it down by one. Two 1-bit indices travel with the count. One points at the buffer software works on, the other at the buffer the engine uses next.

Top module: `usb_ep_handshake`

## Requirements
- R1: `cmd_rdata` always reads 0. Command bits 7 and 6 are reserved, and writing them changes no output.
- R2: A command takes effect only when `cmd_we` is 1, and only for the bits written as 1. The bits are: 0 setup read-complete, 1 control IN load, 2 control OUT read-complete, 3 single IN load, 4 double-buffered IN load, 5 double-buffered OUT read-complete.
- R3: Reset puts the control endpoint in CTL_HOLD with its IN buffer not ready and its OUT buffer owned by the CPU. It sets the single IN endpoint to SI_EMPTY and both double-buffered endpoints to DB_NONE with both indices at 0. So every ACK output is 0 (NAK) and every index output is 0.
- R4: In CTL_HOLD, `ctl_in_ack` and `ctl_out_ack` are 0. Command bit 0 moves CTL_HOLD to CTL_DATA and has no effect in CTL_DATA. If `ev_setup` arrives in the same cycle as bit 0, the endpoint stays in CTL_HOLD.
- R5: `ev_setup` is honoured in any state. It enters CTL_HOLD, clears control IN readiness and returns the control OUT buffer to the CPU, overriding any command in the same cycle.
- R6: `ctl_out_ack` is 1 in CTL_DATA while the control OUT buffer is free. Bit 0 in CTL_HOLD and bit 2 in either state free the buffer. An accepted `ev_ctl_out_rx` gives it back to the CPU, taking precedence over bit 2 in the same cycle.
- R7: Bit 1 makes the control IN buffer ready, and `ctl_in_ack` is 1 in CTL_DATA while it is ready. An accepted `ev_ctl_in_ack` clears readiness unless bit 1 is written in the same cycle.
- R8: Bit 3 moves the single IN endpoint to SI_LOADED, where `sin_ack` is 1. An accepted `ev_sin_ack` returns it to SI_EMPTY unless bit 3 is written in the same cycle.
- R9: On a double-buffered endpoint, its command bit (4 for IN, 5 for OUT) hands the buffer at the CPU index to the engine and toggles the CPU index. When the engine already holds both buffers, the bit has no effect.
- R10: A double-buffered ACK output is 1 while the engine holds at least one buffer. An accepted engine event (`ev_din_ack` or `ev_dout_rx`) returns the buffer at the engine index to the CPU and toggles the engine index.
- R11: An engine event that arrives while its endpoint's ACK output is 0 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_we | input | 1 | Command write strobe from the CPU |
| cmd_wdata | input | 8 | Command bits, one-shot per bit written as 1 |
| cmd_rdata | output | 8 | Command port read data, always 0 |
| ev_setup | input | 1 | Engine stored a setup packet |
| ev_ctl_out_rx | input | 1 | Engine stored a control OUT packet |
| ev_ctl_in_ack | input | 1 | Host acknowledged a control IN packet |
| ev_sin_ack | input | 1 | Host acknowledged a single IN endpoint packet |
| ev_din_ack | input | 1 | Host acknowledged a double-buffered IN packet |
| ev_dout_rx | input | 1 | Engine stored a double-buffered OUT packet |
| ctl_in_ack | output | 1 | Control IN response: 1 ACK, 0 NAK |
| ctl_out_ack | output | 1 | Control OUT response: 1 ACK, 0 NAK |
| sin_ack | output | 1 | Single IN response: 1 ACK, 0 NAK |
| din_ack | output | 1 | Double-buffered IN response: 1 ACK, 0 NAK |
| din_cpu_sel | output | 1 | Buffer index software fills next (IN) |
| din_eng_sel | output | 1 | Buffer index the engine sends next (IN) |
| dout_ack | output | 1 | Double-buffered OUT response: 1 ACK, 0 NAK |
| dout_cpu_sel | output | 1 | Buffer index software reads next (OUT) |
| dout_eng_sel | output | 1 | Buffer index the engine fills next (OUT) |

## Verification
The bench walks through all 256 command values and then runs long stretches of mixed traffic in which events often arrive while an endpoint NAKs. Any design that reacts to an unaccepted event shows this as an index or ACK that drifts away from the expected values.

Directed steps target the same-cycle clashes. In one, a setup packet meets the setup read-complete: a design that lets the command win opens the data stage too early. In another, a received OUT packet meets a read-complete: a design that lets the command win ACKs a buffer that is still full.

The double-buffered endpoints are filled past both buffers. A design that accepts a third command toggles its CPU index and loses track of which buffer the engine holds.

// File: rtl/usb_hs_pkg.sv
package usb_hs_pkg;

    localparam int TRIG_N      = 6;
    localparam int T_SETUP_DONE = 0;
    localparam int T_CIN_LOAD   = 1;
    localparam int T_COUT_DONE  = 2;
    localparam int T_SIN_LOAD   = 3;
    localparam int T_DIN_LOAD   = 4;
    localparam int T_DOUT_DONE  = 5;
    localparam int NUM_DB       = 2;

    typedef enum logic {
        CTL_HOLD,
        CTL_DATA
    } ctl_st_e;

    typedef enum logic {
        SI_EMPTY,
        SI_LOADED
    } sin_st_e;

    typedef enum logic [1:0] {
        DB_NONE,
        DB_ONE,
        DB_BOTH
    } db_st_e;

endpackage

// File: rtl/usb_hs_ctl.sv
module usb_hs_ctl
    import usb_hs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic setup_rx,
    input  logic trg_setup_done,
    input  logic trg_in_load,
    input  logic trg_out_done,
    input  logic out_rx,
    input  logic in_acked,
    output logic in_ack,
    output logic out_ack
);

    ctl_st_e st, st_n;
    logic    in_rdy, in_rdy_n;
    logic    out_busy, out_busy_n;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st       <= CTL_HOLD;
            in_rdy   <= 1'b0;
            out_busy <= 1'b1;
        end else begin
            st       <= st_n;
            in_rdy   <= in_rdy_n;
            out_busy <= out_busy_n;
        end
    end

    // next state and buffer flags
    always_comb begin
        unique case (st)
            CTL_HOLD: st_n = trg_setup_done ? CTL_DATA : CTL_HOLD;
            CTL_DATA: st_n = CTL_DATA;
        endcase

        if (trg_in_load)
            in_rdy_n = 1'b1;
        else if (in_acked && in_ack)
            in_rdy_n = 1'b0;
        else
            in_rdy_n = in_rdy;

        if (out_rx && out_ack)
            out_busy_n = 1'b1;
        else if (trg_out_done || (st == CTL_HOLD && trg_setup_done))
            out_busy_n = 1'b0;
        else
            out_busy_n = out_busy;

        // a new setup packet overrides everything
        if (setup_rx) begin
            st_n       = CTL_HOLD;
            in_rdy_n   = 1'b0;
            out_busy_n = 1'b1;
        end
    end

    // outputs
    always_comb begin
        unique case (st)
            CTL_HOLD: begin
                in_ack  = 1'b0;
                out_ack = 1'b0;
            end
            CTL_DATA: begin
                in_ack  = in_rdy;
                out_ack = !out_busy;
            end
        endcase
    end

endmodule

// File: rtl/usb_hs_single.sv
module usb_hs_single
    import usb_hs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic trg_load,
    input  logic acked,
    output logic ack
);

    sin_st_e st, st_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st <= SI_EMPTY;
        else
            st <= st_n;
    end

    always_comb begin
        unique case (st)
            SI_EMPTY:  st_n = trg_load ? SI_LOADED : SI_EMPTY;
            SI_LOADED: st_n = (acked && !trg_load) ? SI_EMPTY : SI_LOADED;
        endcase
    end

    always_comb begin
        unique case (st)
            SI_EMPTY:  ack = 1'b0;
            SI_LOADED: ack = 1'b1;
        endcase
    end

endmodule

// File: rtl/usb_hs_dbuf.sv
module usb_hs_dbuf
    import usb_hs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sw_trg,
    input  logic eng_done,
    output logic ack,
    output logic cpu_sel,
    output logic eng_sel
);

    db_st_e st, st_n;
    logic   take, give;
    logic   cpu_sel_n, eng_sel_n;

    // a handover is accepted only when a buffer is available for it
    assign take = sw_trg && (st != DB_BOTH);
    assign give = eng_done && (st != DB_NONE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st      <= DB_NONE;
            cpu_sel <= 1'b0;
            eng_sel <= 1'b0;
        end else begin
            st      <= st_n;
            cpu_sel <= cpu_sel_n;
            eng_sel <= eng_sel_n;
        end
    end

    always_comb begin
        unique case (st)
            DB_NONE: st_n = take ? DB_ONE : DB_NONE;
            DB_ONE: begin
                if (take && !give)
                    st_n = DB_BOTH;
                else if (give && !take)
                    st_n = DB_NONE;
                else
                    st_n = DB_ONE;
            end
            DB_BOTH: st_n = give ? DB_ONE : DB_BOTH;
            default: st_n = DB_NONE;
        endcase
        cpu_sel_n = cpu_sel ^ take;
        eng_sel_n = eng_sel ^ give;
    end

    always_comb begin
        unique case (st)
            DB_NONE: ack = 1'b0;
            DB_ONE:  ack = 1'b1;
            DB_BOTH: ack = 1'b1;
            default: ack = 1'b0;
        endcase
    end

endmodule

// File: rtl/usb_ep_handshake.sv
module usb_ep_handshake
    import usb_hs_pkg::*;
#(
    parameter int CMD_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_we,
    input  logic [CMD_W-1:0] cmd_wdata,
    output logic [CMD_W-1:0] cmd_rdata,
    input  logic             ev_setup,
    input  logic             ev_ctl_out_rx,
    input  logic             ev_ctl_in_ack,
    input  logic             ev_sin_ack,
    input  logic             ev_din_ack,
    input  logic             ev_dout_rx,
    output logic             ctl_in_ack,
    output logic             ctl_out_ack,
    output logic             sin_ack,
    output logic             din_ack,
    output logic             din_cpu_sel,
    output logic             din_eng_sel,
    output logic             dout_ack,
    output logic             dout_cpu_sel,
    output logic             dout_eng_sel
);

    localparam int RSVD_W = CMD_W - TRIG_N;

    logic [TRIG_N-1:0] trig_vec;
    logic [RSVD_W-1:0] rsvd_bits;
    logic              rsvd_unused;

    // one-shot decode: nothing is held, reads return zero
    assign trig_vec    = cmd_we ? cmd_wdata[TRIG_N-1:0] : '0;
    assign rsvd_bits   = cmd_wdata[CMD_W-1:TRIG_N];
    assign rsvd_unused = ^rsvd_bits;
    assign cmd_rdata   = '0;

    usb_hs_ctl u_ctl (
        .clk            (clk),
        .rst_n          (rst_n),
        .setup_rx       (ev_setup),
        .trg_setup_done (trig_vec[T_SETUP_DONE]),
        .trg_in_load    (trig_vec[T_CIN_LOAD]),
        .trg_out_done   (trig_vec[T_COUT_DONE]),
        .out_rx         (ev_ctl_out_rx),
        .in_acked       (ev_ctl_in_ack),
        .in_ack         (ctl_in_ack),
        .out_ack        (ctl_out_ack)
    );

    usb_hs_single u_sin (
        .clk      (clk),
        .rst_n    (rst_n),
        .trg_load (trig_vec[T_SIN_LOAD]),
        .acked    (ev_sin_ack),
        .ack      (sin_ack)
    );

    // index 0: double-buffered IN, index 1: double-buffered OUT
    logic [NUM_DB-1:0] db_trg, db_done, db_ack, db_cpu, db_eng;

    assign db_trg  = {trig_vec[T_DOUT_DONE], trig_vec[T_DIN_LOAD]};
    assign db_done = {ev_dout_rx, ev_din_ack};

    for (genvar g = 0; g < NUM_DB; g++) begin : g_db
        usb_hs_dbuf u_db (
            .clk      (clk),
            .rst_n    (rst_n),
            .sw_trg   (db_trg[g]),
            .eng_done (db_done[g]),
            .ack      (db_ack[g]),
            .cpu_sel  (db_cpu[g]),
            .eng_sel  (db_eng[g])
        );
    end

    assign din_ack      = db_ack[0];
    assign din_cpu_sel  = db_cpu[0];
    assign din_eng_sel  = db_eng[0];
    assign dout_ack     = db_ack[1];
    assign dout_cpu_sel = db_cpu[1];
    assign dout_eng_sel = db_eng[1];

endmodule

// File: rtl/usb_ep_handshake_chk.sv
module usb_ep_handshake_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [5:0] trig,
    input logic       ev_setup,
    input logic       ev_ctl_out_rx,
    input logic       ev_sin_ack,
    input logic       ev_din_ack,
    input logic       ctl_in_ack,
    input logic       ctl_out_ack,
    input logic       sin_ack,
    input logic       din_ack,
    input logic       din_cpu_sel,
    input logic       din_eng_sel,
    input logic       dout_ack,
    input logic       dout_cpu_sel,
    input logic       dout_eng_sel
);

    p_setup_nak_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ev_setup |=> (!ctl_in_ack && !ctl_out_ack));

    p_ctl_in_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_in_ack && !trig[1] && !trig[0]) |=> !ctl_in_ack);

    p_ctl_out_taken_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_out_ack && ev_ctl_out_rx) |=> !ctl_out_ack);

    p_ctl_out_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_out_ack && !trig[2] && !trig[0]) |=> !ctl_out_ack);

    p_sin_armed_r8: assert property (@(posedge clk) disable iff (!rst_n)
        trig[3] |=> sin_ack);

    p_sin_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (sin_ack && ev_sin_ack && !trig[3]) |=> !sin_ack);

    p_din_cpu_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (trig[4] && !(din_ack && din_cpu_sel == din_eng_sel))
        |=> (din_cpu_sel != $past(din_cpu_sel)));

    p_dout_cpu_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (trig[5] && !(dout_ack && dout_cpu_sel == dout_eng_sel))
        |=> (dout_cpu_sel != $past(dout_cpu_sel)));

    p_din_eng_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (din_ack && ev_din_ack) |=> (din_eng_sel != $past(din_eng_sel)));

    p_dout_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !dout_ack |=> $stable(dout_eng_sel));

endmodule

bind usb_ep_handshake usb_ep_handshake_chk chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .trig          (trig_vec),
    .ev_setup      (ev_setup),
    .ev_ctl_out_rx (ev_ctl_out_rx),
    .ev_sin_ack    (ev_sin_ack),
    .ev_din_ack    (ev_din_ack),
    .ctl_in_ack    (ctl_in_ack),
    .ctl_out_ack   (ctl_out_ack),
    .sin_ack       (sin_ack),
    .din_ack       (din_ack),
    .din_cpu_sel   (din_cpu_sel),
    .din_eng_sel   (din_eng_sel),
    .dout_ack      (dout_ack),
    .dout_cpu_sel  (dout_cpu_sel),
    .dout_eng_sel  (dout_eng_sel)
);

// File: tb/usb_ep_handshake_tb_top.sv
module usb_ep_handshake_tb_top;

    localparam int CLK_P     = 10;
    localparam int WDOG_CYC  = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_we = 1'b0;
    logic [7:0] cmd_wdata = '0;
    logic [7:0] cmd_rdata;
    logic [5:0] ev = '0;
    logic       ctl_in_ack, ctl_out_ack, sin_ack;
    logic       din_ack, din_cpu_sel, din_eng_sel;
    logic       dout_ack, dout_cpu_sel, dout_eng_sel;

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    // expected state
    bit m_hold, m_ci, m_cob, m_si;
    int m_cnt [2];
    bit m_cs [2];
    bit m_es [2];

    always #(CLK_P/2) clk = ~clk;

    usb_ep_handshake dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .cmd_we        (cmd_we),
        .cmd_wdata     (cmd_wdata),
        .cmd_rdata     (cmd_rdata),
        .ev_setup      (ev[0]),
        .ev_ctl_out_rx (ev[1]),
        .ev_ctl_in_ack (ev[2]),
        .ev_sin_ack    (ev[3]),
        .ev_din_ack    (ev[4]),
        .ev_dout_rx    (ev[5]),
        .ctl_in_ack    (ctl_in_ack),
        .ctl_out_ack   (ctl_out_ack),
        .sin_ack       (sin_ack),
        .din_ack       (din_ack),
        .din_cpu_sel   (din_cpu_sel),
        .din_eng_sel   (din_eng_sel),
        .dout_ack      (dout_ack),
        .dout_cpu_sel  (dout_cpu_sel),
        .dout_eng_sel  (dout_eng_sel)
    );

    task automatic model_reset();
        m_hold = 1'b1; m_ci = 1'b0; m_cob = 1'b1; m_si = 1'b0;
        for (int k = 0; k < 2; k++) begin
            m_cnt[k] = 0; m_cs[k] = 1'b0; m_es[k] = 1'b0;
        end
    endtask

    task automatic model_step(input bit we, input bit [7:0] wd, input bit [5:0] e);
        bit [7:0] t;
        bit ci_a, co_a, trg, evk, take, give;
        t    = we ? wd : 8'h00;
        ci_a = !m_hold && m_ci;
        co_a = !m_hold && !m_cob;
        if (e[0]) begin
            m_hold = 1'b1; m_ci = 1'b0; m_cob = 1'b1;
        end else begin
            if (t[1]) m_ci = 1'b1;
            else if (e[2] && ci_a) m_ci = 1'b0;
            if (e[1] && co_a) m_cob = 1'b1;
            else if (t[2] || (m_hold && t[0])) m_cob = 1'b0;
            m_hold = m_hold && !t[0];
        end
        if (t[3]) m_si = 1'b1;
        else if (e[3]) m_si = 1'b0;
        for (int k = 0; k < 2; k++) begin
            trg  = (k == 0) ? t[4] : t[5];
            evk  = (k == 0) ? e[4] : e[5];
            take = trg && (m_cnt[k] != 2);
            give = evk && (m_cnt[k] != 0);
            m_cnt[k] = m_cnt[k] + int'(take) - int'(give);
            m_cs[k]  = m_cs[k] ^ take;
            m_es[k]  = m_es[k] ^ give;
        end
    endtask

    task automatic cmp(input string what, input string req, input logic act,
                       input logic exp, input string tag);
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s [%s]: got %0b expected %0b", req, what, tag, act, exp);
        end
    endtask

    task automatic check(input string tag);
        vectors++;
        if (cmd_rdata !== 8'h00) begin
            miscompares++;
            $display("FAIL R1 cmd_rdata [%s]: got %0h expected 0", tag, cmd_rdata);
        end
        cmp("ctl_in_ack",   "R7",  ctl_in_ack,   !m_hold && m_ci,  tag);
        cmp("ctl_out_ack",  "R6",  ctl_out_ack,  !m_hold && !m_cob, tag);
        cmp("sin_ack",      "R8",  sin_ack,      m_si,             tag);
        cmp("din_ack",      "R10", din_ack,      m_cnt[0] != 0,    tag);
        cmp("din_cpu_sel",  "R9",  din_cpu_sel,  m_cs[0],          tag);
        cmp("din_eng_sel",  "R10", din_eng_sel,  m_es[0],          tag);
        cmp("dout_ack",     "R10", dout_ack,     m_cnt[1] != 0,    tag);
        cmp("dout_cpu_sel", "R9",  dout_cpu_sel, m_cs[1],          tag);
        cmp("dout_eng_sel", "R10", dout_eng_sel, m_es[1],          tag);
    endtask

    // drive at a falling edge, check at the next falling edge
    task automatic step(input bit we, input bit [7:0] wd, input bit [5:0] e,
                        input string tag);
        cmd_we    = we;
        cmd_wdata = wd;
        ev        = e;
        model_step(we, wd, e);
        @(negedge clk);
        check(tag);
    endtask

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        check("R3 in reset");
        rst_n = 1'b1;
        check("R3 after release");

        // control endpoint sequence
        step(1'b1, 8'h01, 6'h00, "R4 open data stage");
        step(1'b1, 8'h02, 6'h00, "R7 load control IN");
        step(1'b0, 8'h00, 6'h04, "R7 control IN acknowledged");
        step(1'b1, 8'h02, 6'h00, "R7 reload control IN");
        step(1'b0, 8'h00, 6'h01, "R5 setup clears");
        step(1'b1, 8'h06, 6'h00, "R4 triggers while held");
        step(1'b1, 8'h01, 6'h01, "R4 setup beats read-complete");
        step(1'b1, 8'h01, 6'h00, "R4 release");
        step(1'b1, 8'h04, 6'h02, "R6 packet beats read-complete");
        step(1'b0, 8'h00, 6'h02, "R11 OUT while busy");
        step(1'b1, 8'h04, 6'h00, "R6 read-complete");
        step(1'b1, 8'h01, 6'h00, "R4 setup trigger in data stage");
        step(1'b1, 8'hc0, 6'h00, "R1 reserved bits");
        step(1'b0, 8'h3f, 6'h00, "R2 strobe low");

        // double-buffer fill and drain
        for (int i = 0; i < 3; i++) step(1'b1, 8'h30, 6'h00, "R9 fill both");
        step(1'b1, 8'h30, 6'h30, "R9 trigger with event");
        for (int i = 0; i < 3; i++) step(1'b0, 8'h00, 6'h30, "R10 drain");
        step(1'b0, 8'h00, 6'h38, "R11 events under NAK");
        step(1'b1, 8'h08, 6'h08, "R8 load beats acknowledge");
        step(1'b0, 8'h00, 6'h08, "R8 acknowledge");

        // every command value, with random events
        for (int v = 0; v < 256; v++) begin
            bit [5:0] e;
            e = 6'($urandom) & 6'h3e;
            step(1'b1, 8'(v), e, "R2 command sweep");
        end

        // strobe low with random data
        for (int i = 0; i < 500; i++) begin
            bit [5:0] e;
            e = 6'($urandom) & 6'h3e;
            step(1'b0, 8'($urandom), e, "R2 strobe low sweep");
        end

        // mixed traffic
        for (int i = 0; i < 4000; i++) begin
            bit [5:0] e;
            bit we;
            e = 6'($urandom) & 6'h3e;
            if (($urandom % 16) == 0) e[0] = 1'b1;
            we = (($urandom % 3) == 0);
            step(we, 8'($urandom), e, "R11 mixed traffic");
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        #(CLK_P * WDOG_CYC);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule